// File: doc/BRIEF.md
# SIMD Bitwise Select Execution Unit

This unit decodes and runs the three-operand bitwise merge instructions of a SIMD pipeline. It holds a vector register file of 32 entries of 64 bits each. An instruction arrives as a 32-bit word with a valid strobe. A separate flag tells the unit which of the two instruction-set encodings the word uses. The unit checks every fixed opcode bit and assembles the split 5-bit register numbers. It then applies one of three merge rules:

- insert-if-false: source bits land where the mask is clear;
- insert-if-true: source bits land where the mask is set;
- select: the old destination acts as the mask.

A word can work on one 64-bit register. It can also work on an even-aligned pair of registers, which acts as one 128-bit register.

Every accepted word gives one outcome: either a one-cycle `done` pulse or a one-cycle `undef` pulse. An undefined word leaves the register file untouched. A combinational debug port reads any register, so the register file can be observed from outside.

Top module: `vbitsel_unit`

## Requirements
- R1: After reset `done` and `undef` are 0. Register i holds {32'h9E3779B9*(i+1), 32'h85EBCA6B ^ (i*32'h01010101)}, with both products truncated to 32 bits.
- R2: A word is legal only if all of these hold: bits 31:24 equal 8'hF3 when `alt_enc`=0, or 8'hFF when `alt_enc`=1; bit 23 = 0; bits 11:8 = 4'b0001; bit 4 = 1. Any other word gives `undef` and writes nothing.
- R3: The op field is bits 21:20. With op=2'b11 (insert-if-false), the unit writes d = (d & m) | (n & ~m). The register numbers are d={bit22,bits15:12}, n={bit7,bits19:16} and m={bit5,bits3:0}.
- R4: With op=2'b10 (insert-if-true), the unit writes d = (n & m) | (d & ~m).
- R5: With op=2'b01 (select), the unit writes d = (n & d) | (m & ~d).
- R6: op=2'b00 is undefined: `undef` pulses and no register changes.
- R7: With bit 6 = 1 (128-bit form), the rule is applied twice, once for r=0 and once for r=1. Each pass uses registers d+r, n+r and m+r.
- R8: In the 128-bit form, an odd d, n or m makes the word undefined, and no register changes.
- R9: All operands are read before any write takes effect. This holds even when the destination equals a source, or overlaps one in the pair form.
- R10: A word accepted at a rising edge with `insn_valid`=1 raises exactly one of `done` or `undef` for the following cycle. When `insn_valid` is 0, both stay 0 in the next cycle.
- R11: Registers outside the destination register or destination pair never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn_word | input | 32 | Instruction word |
| alt_enc | input | 1 | 0: first encoding (top byte F3), 1: second encoding (top byte FF) |
| dbg_addr | input | 5 | Debug read register number |
| dbg_data | output | 64 | Contents of register `dbg_addr` |
| done | output | 1 | One-cycle pulse: instruction executed |
| undef | output | 1 | One-cycle pulse: instruction rejected |

## Verification
The bench sweeps all four op codes against both encodings and both widths, over many register triples. The triples include cases where the destination aliases a source. A unit that wrote lane 0 before reading lane 1 would corrupt overlapping pair results. A unit that swapped mask and destination in select would give wrong bits. A unit that wrapped an odd pair base instead of rejecting it would alter a neighbouring register. Each fixed opcode bit is flipped in turn, and a word is given with the wrong encoding flag. A lax decoder would then execute and change the file where it should have pulsed `undef`.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   localparam int RIDX_W = 5;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_BSL  = 2'b01,
      OP_BIT  = 2'b10,
      OP_BIF  = 2'b11
   } vbs_op_e;

   typedef struct packed {
      logic              legal;
      vbs_op_e           op;
      logic              pair;
      logic [RIDX_W-1:0] rd;
      logic [RIDX_W-1:0] rn;
      logic [RIDX_W-1:0] rm;
   } vbs_dec_t;

   function automatic logic [63:0] reset_seed(input int idx);
      logic [31:0] hi, lo;
      hi = 32'h9E3779B9 * 32'(idx + 1);
      lo = 32'h85EBCA6B ^ (32'(idx) * 32'h01010101);
      return {hi, lo};
   endfunction
endpackage

// File: rtl/vbs_decode.sv
module vbs_decode
   import vbs_pkg::*;
(
   input  logic [31:0] word,
   input  logic        alt,
   output vbs_dec_t    dec
);
   localparam logic [7:0] TOP_A = 8'hF3;
   localparam logic [7:0] TOP_B = 8'hFF;

   logic fixed_ok;
   logic align_ok;

   always_comb begin
      dec.op   = vbs_op_e'(word[21:20]);
      dec.pair = word[6];
      dec.rd   = {word[22], word[15:12]};
      dec.rn   = {word[7],  word[19:16]};
      dec.rm   = {word[5],  word[3:0]};
      fixed_ok = (word[31:24] == (alt ? TOP_B : TOP_A)) &&
                 (word[23] == 1'b0) &&
                 (word[11:8] == 4'b0001) &&
                 (word[4] == 1'b1);
      align_ok = !dec.pair || !(dec.rd[0] || dec.rn[0] || dec.rm[0]);
      dec.legal = fixed_ok && align_ok && (dec.op != OP_NONE);
   end
endmodule

// File: rtl/vbs_lane.sv
module vbs_lane
   import vbs_pkg::*;
#(
   parameter int LANE_W = 64
) (
   input  vbs_op_e           op,
   input  logic [LANE_W-1:0] dv,
   input  logic [LANE_W-1:0] nv,
   input  logic [LANE_W-1:0] mv,
   output logic [LANE_W-1:0] res
);
   always_comb begin
      unique case (op)
         OP_BIF:  res = (dv & mv) | (nv & ~mv);
         OP_BIT:  res = (nv & mv) | (dv & ~mv);
         OP_BSL:  res = (nv & dv) | (mv & ~dv);
         default: res = dv;
      endcase
   end
endmodule

// File: rtl/vbs_regfile.sv
module vbs_regfile
   import vbs_pkg::*;
#(
   parameter int LANE_W   = 64,
   parameter int NUM_REGS = 32,
   parameter int NRD      = 6,
   parameter int NWR      = 2,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr [NRD],
   output logic [LANE_W-1:0] rd_data [NRD],
   input  logic [AW-1:0]     dbg_addr,
   output logic [LANE_W-1:0] dbg_data,
   input  logic              we      [NWR],
   input  logic [AW-1:0]     wa      [NWR],
   input  logic [LANE_W-1:0] wd      [NWR]
);
   logic [LANE_W-1:0] mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++)
            mem[i] <= LANE_W'(reset_seed(i));
      end else begin
         for (int w = 0; w < NWR; w++)
            if (we[w]) mem[wa[w]] <= wd[w];
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rd_data[p] = mem[rd_addr[p]];
   end
   assign dbg_data = mem[dbg_addr];

   for (genvar w = 1; w < NWR; w++) begin : g_wchk
      // R7: upper lane of a pair is only written together with lane 0, to a different register
      p_pair_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
         we[w] |-> (we[0] && wa[w] != wa[0]));
   end
endmodule

// File: rtl/vbitsel_unit.sv
module vbitsel_unit
   import vbs_pkg::*;
#(
   parameter int LANE_W    = 64,
   parameter int NUM_REGS  = 32,
   parameter int MAX_LANES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        insn_valid,
   input  logic [31:0]                 insn_word,
   input  logic                        alt_enc,
   input  logic [$clog2(NUM_REGS)-1:0] dbg_addr,
   output logic [LANE_W-1:0]           dbg_data,
   output logic                        done,
   output logic                        undef
);
   localparam int AW  = $clog2(NUM_REGS);
   localparam int NRD = 3 * MAX_LANES;

   if (AW != RIDX_W || NUM_REGS != (1 << AW)) begin : g_bad_regs
      $error("NUM_REGS must match the 5-bit register fields");
   end
   if (MAX_LANES < 1 || MAX_LANES > 2) begin : g_bad_lanes
      $error("MAX_LANES must be 1 or 2");
   end
   if (LANE_W < 1 || LANE_W > 64) begin : g_bad_width
      $error("LANE_W must be 1..64");
   end

   vbs_dec_t dec;
   logic     legal;
   logic     go;

   vbs_decode u_dec (.word(insn_word), .alt(alt_enc), .dec(dec));

   assign legal = dec.legal && (!dec.pair || MAX_LANES > 1);
   assign go    = insn_valid && legal;

   logic [AW-1:0]     rd_addr [NRD];
   logic [LANE_W-1:0] rd_data [NRD];
   logic              we      [MAX_LANES];
   logic [AW-1:0]     wa      [MAX_LANES];
   logic [LANE_W-1:0] wd      [MAX_LANES];

   for (genvar r = 0; r < MAX_LANES; r++) begin : g_lane
      assign rd_addr[3*r]   = dec.rd + AW'(r);
      assign rd_addr[3*r+1] = dec.rn + AW'(r);
      assign rd_addr[3*r+2] = dec.rm + AW'(r);
      assign wa[r]          = dec.rd + AW'(r);
      if (r == 0) begin : g_base
         assign we[r] = go;
      end else begin : g_upper
         assign we[r] = go && dec.pair;
      end
      vbs_lane #(.LANE_W(LANE_W)) u_lane (
         .op (dec.op),
         .dv (rd_data[3*r]),
         .nv (rd_data[3*r+1]),
         .mv (rd_data[3*r+2]),
         .res(wd[r])
      );
   end

   vbs_regfile #(
      .LANE_W(LANE_W), .NUM_REGS(NUM_REGS), .NRD(NRD), .NWR(MAX_LANES)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dbg_addr(dbg_addr), .dbg_data(dbg_data),
      .we(we), .wa(wa), .wd(wd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         undef <= 1'b0;
      end else begin
         done  <= go;
         undef <= insn_valid && !legal;
      end
   end

   // R10: outcomes are exclusive
   p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && undef));
   // R10: a pulse needs a word in the previous cycle
   p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || undef) |-> $past(insn_valid));
   // R10: no strobe, no pulse
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !insn_valid |=> !(done || undef));
   // R8: an odd base in pair form never gives done
   p_pair_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_word[6] && (insn_word[12] || insn_word[16] || insn_word[0]))
      |=> !done);
endmodule

// File: tb/tb_vbitsel_unit.sv
`timescale 1ns/1ps
module tb_vbitsel_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn_word = '0;
   logic        alt_enc = 1'b0;
   logic [4:0]  dbg_addr = '0;
   logic [63:0] dbg_data;
   logic        done, undef;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;
   logic [63:0] model [32];

   always #4 clk = ~clk;

   vbitsel_unit dut (.*);

   function automatic logic [63:0] seed(input int i);
      logic [31:0] hi, lo;
      hi = 32'h9E3779B9 * 32'(i + 1);
      lo = 32'h85EBCA6B ^ (32'(i) * 32'h01010101);
      return {hi, lo};
   endfunction

   function automatic logic [31:0] mk(input bit alt, input logic [1:0] op,
      input logic [4:0] d, input logic [4:0] n, input logic [4:0] m, input bit q);
      return {(alt ? 8'hFF : 8'hF3), 1'b0, d[4], op, n[3:0], d[3:0], 4'b0001,
              n[4], q, m[4], 1'b1, m[3:0]};
   endfunction

   task automatic check_bit(input string tag, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic dump_check(input string tag);
      int bad;
      bad = -1;
      for (int i = 0; i < 32; i++) begin
         dbg_addr = 5'(i);
         #0.1;
         if (dbg_data !== model[i] && bad < 0) begin
            bad = i;
            errors++;
            $display("FAIL %s reg%0d actual=%h expected=%h", tag, i, dbg_data, model[i]);
         end
      end
      checks++;
   endtask

   // issue one word, apply the spec model, check the pulse and the whole file
   task automatic issue(input logic [31:0] w, input bit alt, input bit exp_bad, input string tag);
      logic [63:0] old [32];
      logic [1:0] op;
      logic [4:0] d, n, m;
      int lanes;
      @(negedge clk);
      insn_word = w; alt_enc = alt; insn_valid = 1'b1;
      @(negedge clk);
      insn_valid = 1'b0;
      check_bit(tag, done, !exp_bad, "done");
      check_bit({tag, "/R10"}, undef, exp_bad, "undef");
      if (!exp_bad) begin
         for (int i = 0; i < 32; i++) old[i] = model[i];
         op = w[21:20]; d = {w[22], w[15:12]}; n = {w[7], w[19:16]}; m = {w[5], w[3:0]};
         lanes = w[6] ? 2 : 1;
         for (int r = 0; r < lanes; r++) begin
            logic [63:0] dv, nv, mv;
            dv = old[5'(d + 5'(r))]; nv = old[5'(n + 5'(r))]; mv = old[5'(m + 5'(r))];
            case (op)
               2'b11: model[5'(d + 5'(r))] = (dv & mv) | (nv & ~mv);
               2'b10: model[5'(d + 5'(r))] = (nv & mv) | (dv & ~mv);
               default: model[5'(d + 5'(r))] = (nv & dv) | (mv & ~dv);
            endcase
         end
      end
      @(negedge clk);
      check_bit({tag, "/R10"}, done | undef, 1'b0, "pulse width");
      dump_check({tag, "/R11"});
   endtask

   function automatic string optag(input logic [1:0] op);
      case (op)
         2'b11: return "R3";
         2'b10: return "R4";
         2'b01: return "R5";
         default: return "R6";
      endcase
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
         end
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) model[i] = seed(i);
      repeat (3) @(negedge clk);
      check_bit("R1", done, 1'b0, "done in reset");
      check_bit("R1", undef, 1'b0, "undef in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R1", done | undef, 1'b0, "idle after reset");
      dump_check("R1");

      // idle strobe: legal word but valid low
      insn_word = mk(0, 2'b11, 5'd2, 5'd3, 5'd4, 0);
      @(negedge clk); @(negedge clk);
      check_bit("R10", done | undef, 1'b0, "no strobe");
      dump_check("R10");

      // sweep: op x encoding x width x register triples
      for (int op = 0; op < 4; op++)
         for (int alt = 0; alt < 2; alt++)
            for (int q = 0; q < 2; q++)
               for (int d = 0; d < 32; d += 3) begin
                  logic [4:0] dd, nn, mm;
                  bit bad;
                  string tag;
                  dd = 5'(d);
                  nn = 5'((d * 7 + 2 + q) % 32);
                  mm = 5'((d * 13 + 4 * alt) % 32);
                  if (q == 1 && d % 2 == 1) begin nn[0] = 1'b0; mm[0] = 1'b0; end
                  bad = (op == 0) || (q == 1 && (dd[0] | nn[0] | mm[0]));
                  tag = (op != 0 && q == 1 && bad) ? "R8" : optag(2'(op));
                  if (q == 1 && !bad) tag = {tag, "/R7"};
                  issue(mk(alt[0], 2'(op), dd, nn, mm, q[0]), alt[0], bad, tag);
               end

      // aliasing: destination overlaps sources, read-before-write
      for (int op = 1; op < 4; op++) begin
         issue(mk(0, 2'(op), 5'd6, 5'd6, 5'd6, 1), 0, 0, "R9");
         issue(mk(1, 2'(op), 5'd10, 5'd8, 5'd12, 1), 1, 0, "R9");
         issue(mk(0, 2'(op), 5'd20, 5'd22, 5'd20, 1), 0, 0, "R9");
         issue(mk(1, 2'(op), 5'd31, 5'd0, 5'd31, 0), 1, 0, "R9");
         issue(mk(0, 2'(op), 5'd30, 5'd28, 5'd2, 1), 0, 0, "R9/R7");
      end

      // fixed-bit corruption and wrong encoding flag
      begin
         int fixed_pos [14] = '{31, 30, 29, 28, 27, 26, 25, 24, 23, 11, 10, 9, 8, 4};
         for (int k = 0; k < 14; k++) begin
            logic [31:0] w;
            w = mk(0, 2'b11, 5'd1, 5'd2, 5'd3, 0);
            w[fixed_pos[k]] = ~w[fixed_pos[k]];
            issue(w, 0, 1, "R2");
            w = mk(1, 2'b10, 5'd4, 5'd5, 5'd6, 1);
            w[fixed_pos[k]] = ~w[fixed_pos[k]];
            issue(w, 1, 1, "R2");
         end
         issue(mk(0, 2'b01, 5'd7, 5'd8, 5'd9, 0), 1, 1, "R2");
         issue(mk(1, 2'b01, 5'd7, 5'd8, 5'd9, 0), 0, 1, "R2");
      end

      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule